// File: doc/BRIEF.md
# Integrator Sample-and-Digitize Sequencer

This block orders the capture of a set of analog integrator voltages for conversion. Two trigger sources can start a capture. An external trigger arrives shortly before the beam. A self trigger comes from the signal itself. Each source has its own settling delay before the track/hold amplifiers are frozen by the `hold` output. Both delays are counted in ticks of a slow time base supplied on `tick`. With a 100 µs tick, the defaults give 1.6 ms for the external path and 1.5 ms for the self path.

Once `hold` is up, the block waits a further short gap and then issues a one-cycle `scan_start` to the converter. It keeps `hold` up until the converter reports `scan_done`. On that edge it releases `hold` and marks fresh data on every channel. The host reads one channel at a time through `rd_en`/`rd_ch`. The `rd_q` answer tells the host whether a completed capture has occurred since that channel was last read, and the read consumes the flag.

While a capture is under way, further triggers are ignored, so an external trigger shuts out self triggers for the entire digitisation window. There is one exception: an external trigger arriving while a self-triggered capture is still in its delay restarts timing from the external trigger. A synchronous `clr` abandons any capture and drops all flags.

Top module: `integ_sample_seq`

## Requirements
- R1: A rising edge on `ext_trig` sampled while idle makes `hold` rise on the clock edge that samples the EXT_DLY-th (default 16) subsequent `tick`.
- R2: A rising edge on `self_trig` sampled while idle makes `hold` rise on the clock edge that samples the SELF_DLY-th (default 15) subsequent `tick`, however sparsely ticks arrive.
- R3: `scan_start` is a single-cycle pulse, issued on the edge that samples the GAP_DLY-th (default 1) tick after `hold` rose. `hold` stays high until `scan_done`.
- R4: `scan_done` sampled while waiting for the scan releases `hold` and sets all bits of `ready` (bit i = channel i) on the same edge.
- R5: A rising `ext_trig` during the self-trigger delay aborts it and restarts timing, so `hold` rises EXT_DLY ticks after the external edge.
- R6: Once an external delay, the gap or the scan is under way, triggers from either source are ignored: neither a new `hold` nor a change in timing results.
- R7: Only rising edges start a capture. An `ext_trig` held high for many cycles produces exactly one capture.
- R8: With `rd_en` high and `rd_ch` < N_CH, `rd_q` shows `ready[rd_ch]` in the same cycle and that bit clears at the next edge, other bits untouched. If that channel is being set by `scan_done` on the same edge, the set wins. When `rd_ch` ≥ N_CH, `rd_q` is 0 and nothing changes.
- R9: `clr` returns the sequencer to idle at the next edge (`hold` low, no later `scan_start`) and clears all of `ready`.
- R10: After reset, `hold`, `scan_start`, `rd_q` and `ready` are all 0.
- R11: When both trigger edges are sampled on the same edge, external timing is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Delay time-base strobe, one cycle wide |
| clr | input | 1 | Synchronous abort and flag clear |
| ext_trig | input | 1 | External trigger, rising edge active |
| self_trig | input | 1 | Self trigger, rising edge active |
| scan_done | input | 1 | Converter finished the scan |
| rd_en | input | 1 | Host read strobe |
| rd_ch | input | CH_W | Channel being read |
| hold | output | 1 | Track/hold freeze command |
| scan_start | output | 1 | One-cycle converter start pulse |
| rd_q | output | 1 | Fresh-data answer for the channel read |
| ready | output | N_CH | Per-channel fresh-data flags |

## Verification
The hardest situation to reach is the restart of a self-triggered delay by an external edge, together with its mirror, a self edge landing in an external delay. The restart must reset the count exactly, and the ignored edge must leave the timing unchanged. The stimulus table schedules the second trigger a chosen number of cycles after the first. This covers both an early restart and one a single tick before the self delay would have frozen the amplifiers, and each entry checks the edge count at which `hold` rises. A read of a channel on the very edge that `scan_done` sets its flag is also forced deliberately, by holding a read during the scan wait.

// File: rtl/integ_sample_seq.sv
module integ_sample_seq #(
  parameter int N_CH     = 5,
  parameter int EXT_DLY  = 16,
  parameter int SELF_DLY = 15,
  parameter int GAP_DLY  = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic                        clr,
  input  logic                        ext_trig,
  input  logic                        self_trig,
  input  logic                        scan_done,
  input  logic                        rd_en,
  input  logic [$clog2(N_CH+1)-1:0]   rd_ch,
  output logic                        hold,
  output logic                        scan_start,
  output logic                        rd_q,
  output logic [N_CH-1:0]             ready
);
  localparam int CH_W  = $clog2(N_CH+1);
  localparam int MAXD  = (EXT_DLY > SELF_DLY) ? ((EXT_DLY > GAP_DLY) ? EXT_DLY : GAP_DLY)
                                              : ((SELF_DLY > GAP_DLY) ? SELF_DLY : GAP_DLY);
  localparam int CNT_W = $clog2(MAXD + 1);
  localparam logic [CNT_W-1:0] EXT_LAST  = CNT_W'(EXT_DLY - 1);
  localparam logic [CNT_W-1:0] SELF_LAST = CNT_W'(SELF_DLY - 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_DLY - 1);
  localparam logic [CH_W-1:0]  CH_LIM    = CH_W'(N_CH);

  typedef enum logic [2:0] {S_IDLE, S_WSELF, S_WEXT, S_GAP, S_SCAN} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             ext_q, self_q;
  logic             ext_edge, self_edge, rd_hit;

  assign ext_edge  = ext_trig & ~ext_q;
  assign self_edge = self_trig & ~self_q;
  assign rd_hit    = rd_en && (rd_ch < CH_LIM);
  assign hold      = (st == S_GAP) || (st == S_SCAN);
  assign rd_q      = rd_hit && ready[rd_ch];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q  <= 1'b0;
      self_q <= 1'b0;
    end else begin
      ext_q  <= ext_trig;
      self_q <= self_trig;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      scan_start <= 1'b0;
      ready      <= '0;
    end else begin
      scan_start <= 1'b0;
      if (clr) begin
        st    <= S_IDLE;
        cnt   <= '0;
        ready <= '0;
      end else begin
        if (rd_hit) ready[rd_ch] <= 1'b0;
        case (st)
          S_IDLE: begin
            cnt <= '0;
            if (ext_edge)       st <= S_WEXT;
            else if (self_edge) st <= S_WSELF;
          end
          S_WSELF: begin
            if (ext_edge) begin
              st  <= S_WEXT;
              cnt <= '0;
            end else if (tick) begin
              if (cnt == SELF_LAST) begin
                st  <= S_GAP;
                cnt <= '0;
              end else cnt <= cnt + 1'b1;
            end
          end
          S_WEXT: begin
            if (tick) begin
              if (cnt == EXT_LAST) begin
                st  <= S_GAP;
                cnt <= '0;
              end else cnt <= cnt + 1'b1;
            end
          end
          S_GAP: begin
            if (tick) begin
              if (cnt == GAP_LAST) begin
                st         <= S_SCAN;
                cnt        <= '0;
                scan_start <= 1'b1;
              end else cnt <= cnt + 1'b1;
            end
          end
          S_SCAN: begin
            if (scan_done) begin
              st    <= S_IDLE;
              ready <= '1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r3_start_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |-> hold);

  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |=> !scan_start);

  a_r1_hold_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(tick));

  a_r4_release_and_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SCAN && scan_done && !clr) |=> (!hold && (&ready)));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!hold && ready == '0 && !scan_start));

  a_r6_self_locked_out: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WEXT && !clr) |=> (st != S_WSELF && st != S_IDLE));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !clr && !(st == S_SCAN && scan_done)) |=> !ready[$past(rd_ch)]);

  a_r8_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_ch >= CH_LIM) |-> !rd_q);
endmodule

// File: tb/sim_integ_sample_seq.sv
`timescale 1ns/1ps
module sim_integ_sample_seq;
  localparam int N_CH = 5;
  localparam int CH_W = $clog2(N_CH+1);

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, clr = 1'b0;
  logic ext_trig = 1'b0, self_trig = 1'b0, scan_done = 1'b0, rd_en = 1'b0;
  logic [CH_W-1:0] rd_ch = '0;
  logic hold, scan_start, rd_q;
  logic [N_CH-1:0] ready;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  integ_sample_seq #(.N_CH(N_CH)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .ext_trig(ext_trig),
    .self_trig(self_trig), .scan_done(scan_done), .rd_en(rd_en), .rd_ch(rd_ch),
    .hold(hold), .scan_start(scan_start), .rd_q(rd_q), .ready(ready));

  // kind[18:16]: 0 ext, 1 self, 2 self then ext at gap, 3 ext then self at gap, 4 both
  localparam logic [18:0] VEC [6] = '{
    {3'd0, 8'd0,  8'd16},
    {3'd1, 8'd0,  8'd15},
    {3'd2, 8'd5,  8'd21},
    {3'd2, 8'd14, 8'd30},
    {3'd3, 8'd4,  8'd16},
    {3'd4, 8'd0,  8'd16}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_scan();
    int n = 0;
    while (!scan_start && n < 40) begin step(); n++; end
    scan_done = 1'b1; step(); scan_done = 1'b0;
  endtask

  task automatic wait_hold(output int n);
    n = 0;
    while (!hold && n < 100) begin step(); n++; end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    string lbl;
    #1;
    step(); step();
    check("R10 hold", hold, 0);
    check("R10 scan_start", scan_start, 0);
    check("R10 ready", ready, 0);
    check("R10 rd_q", rd_q, 0);
    rst_n = 1'b1;
    step();

    for (int i = 0; i < 6; i++) begin
      int kind, gap, exp;
      kind = int'(VEC[i][18:16]); gap = int'(VEC[i][15:8]); exp = int'(VEC[i][7:0]);
      lbl = (kind == 0) ? "R1" : (kind == 1) ? "R2" : (kind == 2) ? "R5" : (kind == 3) ? "R6" : "R11";
      ext_trig  = (kind == 0 || kind == 3 || kind == 4);
      self_trig = (kind == 1 || kind == 2 || kind == 4);
      step();
      ext_trig = 1'b0; self_trig = 1'b0;
      n = 0;
      while (!hold && n < 100) begin
        if (n + 1 == gap && kind == 2) ext_trig = 1'b1;
        if (n + 1 == gap && kind == 3) self_trig = 1'b1;
        step(); n++;
        ext_trig = 1'b0; self_trig = 1'b0;
      end
      check({lbl, " hold delay"}, n, exp);
      n = 0;
      while (!scan_start && n < 20) begin step(); n++; end
      check("R3 scan_start gap", n, 1);
      step();
      check("R3 scan_start one cycle", scan_start, 0);
      check("R3 hold kept until done", hold, 1);
      scan_done = 1'b1; step(); scan_done = 1'b0;
      check("R4 hold released", hold, 0);
      check("R4 ready all set", ready, 5'h1f);
      clr = 1'b1; step(); clr = 1'b0;
      check("R9 ready cleared", ready, 0);
    end

    // R6: triggers during scan wait ignored
    ext_trig = 1'b1; step(); ext_trig = 1'b0;
    wait_hold(n);
    n = 0;
    while (!scan_start && n < 20) begin step(); n++; end
    self_trig = 1'b1; step(); self_trig = 1'b0; step();
    ext_trig = 1'b1; step(); ext_trig = 1'b0; step();
    scan_done = 1'b1; step(); scan_done = 1'b0;
    n = 0;
    for (int k = 0; k < 30; k++) begin step(); if (hold) n++; end
    check("R6 no capture from triggers during scan", n, 0);

    // R8: reads
    rd_en = 1'b1; rd_ch = 3'd2; #0.5;
    check("R8 rd_q shows flag", rd_q, 1);
    step();
    check("R8 rd_q after consume", rd_q, 0);
    check("R8 only that bit cleared", ready, 5'b11011);
    rd_ch = 3'd7; #0.5;
    check("R8 out-of-range rd_q", rd_q, 0);
    step();
    check("R8 out-of-range no change", ready, 5'b11011);
    rd_en = 1'b0;
    clr = 1'b1; step(); clr = 1'b0;

    // R8: read collides with set
    self_trig = 1'b1; step(); self_trig = 1'b0;
    wait_hold(n);
    n = 0;
    while (!scan_start && n < 20) begin step(); n++; end
    rd_en = 1'b1; rd_ch = 3'd0; scan_done = 1'b1;
    step();
    rd_en = 1'b0; scan_done = 1'b0;
    check("R8 set wins over read", ready, 5'h1f);
    clr = 1'b1; step(); clr = 1'b0;

    // R7: long ext pulse gives one capture
    ext_trig = 1'b1;
    step();
    wait_hold(n);
    check("R7 first capture timing", n, 16);
    finish_scan();
    n = 0;
    for (int k = 0; k < 30; k++) begin step(); if (hold) n++; end
    check("R7 no second capture while level high", n, 0);
    ext_trig = 1'b0; step();
    clr = 1'b1; step(); clr = 1'b0;

    // R9: clr mid-delay
    self_trig = 1'b1; step(); self_trig = 1'b0;
    for (int k = 0; k < 5; k++) step();
    clr = 1'b1; step(); clr = 1'b0;
    check("R9 hold low after clr", hold, 0);
    n = 0;
    for (int k = 0; k < 30; k++) begin step(); if (hold || scan_start) n++; end
    check("R9 no later hold or start", n, 0);

    // R2: sparse ticks, one tick every third cycle
    tick = 1'b0;
    self_trig = 1'b1; step(); self_trig = 1'b0;
    n = 0;
    for (int k = 0; k < 200 && !hold; k++) begin
      tick = (k % 3 == 2);
      step();
      if (tick) n++;
    end
    tick = 1'b1;
    check("R2 hold after 15 ticks", n, 15);
    finish_scan();
    check("R4 flags after sparse run", ready, 5'h1f);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule